// File: doc/BRIEF.md
# Two-Channel Weighted Bus Arbiter

This block decides which of two DMA engines, a transmit engine and a receive engine, owns a single shared data bus for its next access. Each engine raises a request, receives a registered grant, and signals the end of its access with a one-cycle transfer-done pulse. The grant stays with its owner until that pulse, and the bus then passes through one idle cycle in which the next owner is chosen.

Two arbitration schemes are available and can be changed at run time. In the weighted scheme the receive engine is favoured: when both engines compete, it receives a programmable number of grants in a row, and then the transmit engine is given one grant. In the fixed scheme one engine always wins when both compete, and a swap input selects which one. An engine that requests alone is always granted, whatever the scheme. Configuration inputs are only read at arbitration points, so a change made during a transfer applies to the next decision.

Top module: `dma_bus_arbiter`

## Requirements
- R1: The grant outputs are registered and never both high. After reset both grants are low and the weighting counter is zero, so the first weighted contest goes to the receive engine.
- R2: In the idle cycle, an engine that requests alone is granted at the next clock edge, in either scheme.
- R3: In the idle cycle with no request, no grant is issued.
- R4: A grant is held until its owner pulses its own transfer-done; a done pulse from the engine that does not own the bus has no effect on the grants.
- R5: The clock edge that samples the owner's done clears its grant; the following cycle is idle and is the arbitration point, and the new grant appears at the edge after it.
- R6: Fixed scheme (mode input high) with swap input low: when both request, the receive engine is granted.
- R7: Fixed scheme with swap input high: when both request, the transmit engine is granted.
- R8: Weighted scheme (mode input low): the 2-bit ratio field value v sets a limit N = v + 1 (receive:transmit of 1:1, 2:1, 3:1, 4:1). In a contest the transmit engine wins if the counter is at least N, and the counter returns to zero; otherwise the receive engine wins and the counter increments.
- R9: Only weighted contests change the counter; lone grants and fixed-scheme contests leave it unchanged.
- R10: Mode, swap and ratio are sampled only at the arbitration point; a ratio lowered below the current count during a transfer makes the next weighted contest go to the transmit engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Transmit engine requests the bus |
| rx_req | input | 1 | Receive engine requests the bus |
| tx_done | input | 1 | Transmit engine finished its access |
| rx_done | input | 1 | Receive engine finished its access |
| cfg_fixed | input | 1 | 1 selects the fixed scheme, 0 the weighted scheme |
| cfg_tx_first | input | 1 | In the fixed scheme, 1 makes the transmit engine win |
| cfg_ratio | input | 2 | Weighted ratio code v, limit N = v + 1 |
| tx_gnt | output | 1 | Bus granted to the transmit engine |
| rx_gnt | output | 1 | Bus granted to the receive engine |

## Verification
A wrong owner state appears at the ports within one cycle: a grant that outlives its done, a grant that drops early, or two grants together. A wrong weighting count stays hidden until contests happen, and then shows as a grant sequence that departs from the N-to-one pattern within at most N + 1 weighted contests. Lone and fixed-scheme grants placed between weighted contests show that the count is kept exactly, and a ratio change made during a transfer shows that the count is compared against the limit at the decision point.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_TX   = 2'b01,
    OWN_RX   = 2'b10
  } owner_e;

  // Limit of consecutive favoured grants for a ratio code.
  function automatic int unsigned ratio_limit(input int unsigned code);
    return code + 1;
  endfunction

  // Weighted contest: transmit wins once the count has reached the limit.
  function automatic logic weighted_tx_wins(input int unsigned count,
                                            input int unsigned limit);
    return count >= limit;
  endfunction

endpackage

// File: rtl/arb_weight_ctr.sv
module arb_weight_ctr #(
  parameter int RATIO_W = 2,
  localparam int CNT_W = RATIO_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               step,
  output logic [CNT_W-1:0]   count,
  output logic               force_tx
);
  import arb_pkg::*;

  logic [CNT_W-1:0] count_q;

  always_comb begin
    force_tx = weighted_tx_wins(int'(count_q), ratio_limit(int'(ratio)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (step) begin
      if (force_tx) count_q <= '0;
      else          count_q <= count_q + 1'b1;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/arb_decide.sv
module arb_decide (
  input  logic            arb_point,
  input  logic            tx_req,
  input  logic            rx_req,
  input  logic            cfg_fixed,
  input  logic            cfg_tx_first,
  input  logic            force_tx,
  output arb_pkg::owner_e pick,
  output logic            contend,
  output logic            weighted_step
);
  import arb_pkg::*;

  always_comb begin
    contend       = tx_req && rx_req;
    weighted_step = arb_point && contend && !cfg_fixed;
    pick          = OWN_NONE;
    if (arb_point) begin
      if (contend) begin
        if (cfg_fixed) pick = cfg_tx_first ? OWN_TX : OWN_RX;
        else           pick = force_tx ? OWN_TX : OWN_RX;
      end else if (tx_req) begin
        pick = OWN_TX;
      end else if (rx_req) begin
        pick = OWN_RX;
      end
    end
  end
endmodule

// File: rtl/arb_owner_reg.sv
module arb_owner_reg (
  input  logic            clk,
  input  logic            rst_n,
  input  arb_pkg::owner_e pick,
  input  logic            tx_done,
  input  logic            rx_done,
  output arb_pkg::owner_e owner,
  output logic            arb_point
);
  import arb_pkg::*;

  owner_e owner_q, owner_d;

  always_comb begin
    owner_d = owner_q;
    case (owner_q)
      OWN_NONE: owner_d = pick;
      OWN_TX:   if (tx_done) owner_d = OWN_NONE;
      OWN_RX:   if (rx_done) owner_d = OWN_NONE;
      default:  owner_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  assign owner     = owner_q;
  assign arb_point = (owner_q == OWN_NONE);
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_req,
  input  logic               rx_req,
  input  logic               tx_done,
  input  logic               rx_done,
  input  logic               cfg_fixed,
  input  logic               cfg_tx_first,
  input  logic [RATIO_W-1:0] cfg_ratio,
  output logic               tx_gnt,
  output logic               rx_gnt
);
  import arb_pkg::*;
  localparam int CNT_W = RATIO_W + 1;

  // Named internal events, visible to the bound checker.
  logic             arb_point;
  logic             contend;
  logic             weighted_step;
  logic             force_tx;
  logic [CNT_W-1:0] weight_cnt;
  owner_e           pick;
  owner_e           owner;

  arb_weight_ctr #(.RATIO_W(RATIO_W)) u_weight (
    .clk      (clk),
    .rst_n    (rst_n),
    .ratio    (cfg_ratio),
    .step     (weighted_step),
    .count    (weight_cnt),
    .force_tx (force_tx)
  );

  arb_decide u_decide (
    .arb_point     (arb_point),
    .tx_req        (tx_req),
    .rx_req        (rx_req),
    .cfg_fixed     (cfg_fixed),
    .cfg_tx_first  (cfg_tx_first),
    .force_tx      (force_tx),
    .pick          (pick),
    .contend       (contend),
    .weighted_step (weighted_step)
  );

  arb_owner_reg u_owner (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick      (pick),
    .tx_done   (tx_done),
    .rx_done   (rx_done),
    .owner     (owner),
    .arb_point (arb_point)
  );

  assign tx_gnt = (owner == OWN_TX);
  assign rx_gnt = (owner == OWN_RX);
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
  parameter int RATIO_W = 2,
  localparam int CNT_W = RATIO_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_req,
  input logic               rx_req,
  input logic               tx_done,
  input logic               rx_done,
  input logic               cfg_fixed,
  input logic               cfg_tx_first,
  input logic               tx_gnt,
  input logic               rx_gnt,
  input logic               arb_point,
  input logic               contend,
  input logic               force_tx,
  input logic [CNT_W-1:0]   weight_cnt
);
  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_gnt, rx_gnt}));

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    weight_cnt <= CNT_W'(1 << RATIO_W));

  assert_lone_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arb_point && tx_req && !rx_req |=> tx_gnt);

  assert_lone_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arb_point && rx_req && !tx_req |=> rx_gnt);

  assert_no_req_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_point && !tx_req && !rx_req |=> !tx_gnt && !rx_gnt);

  assert_hold_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_gnt && !tx_done |=> tx_gnt);

  assert_hold_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_gnt && !rx_done |=> rx_gnt);

  assert_release_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_gnt && tx_done |=> !tx_gnt && !rx_gnt);

  assert_release_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_gnt && rx_done |=> !tx_gnt && !rx_gnt);

  assert_fixed_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arb_point && contend && cfg_fixed && !cfg_tx_first |=> rx_gnt);

  assert_fixed_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_point && contend && cfg_fixed && cfg_tx_first |=> tx_gnt);

  assert_weight_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arb_point && contend && !cfg_fixed && force_tx |=> tx_gnt && weight_cnt == '0);

  assert_weight_favour_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arb_point && contend && !cfg_fixed && !force_tx |=> rx_gnt);

  assert_cnt_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(arb_point && contend && !cfg_fixed) |=> $stable(weight_cnt));
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.RATIO_W(RATIO_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_req       (tx_req),
  .rx_req       (rx_req),
  .tx_done      (tx_done),
  .rx_done      (rx_done),
  .cfg_fixed    (cfg_fixed),
  .cfg_tx_first (cfg_tx_first),
  .tx_gnt       (tx_gnt),
  .rx_gnt       (rx_gnt),
  .arb_point    (arb_point),
  .contend      (contend),
  .force_tx     (force_tx),
  .weight_cnt   (weight_cnt)
);

// File: tb/dma_bus_arbiter_tb_top.sv
module dma_bus_arbiter_tb_top;
  localparam int WHO_NONE = 0;
  localparam int WHO_TX   = 1;
  localparam int WHO_RX   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_req = 1'b0, rx_req = 1'b0, tx_done = 1'b0, rx_done = 1'b0;
  logic       cfg_fixed = 1'b0, cfg_tx_first = 1'b0;
  logic [1:0] cfg_ratio = 2'd0;
  logic       tx_gnt, rx_gnt;

  int checks = 0;
  int errors = 0;
  int cnt_m  = 0;
  bit finished = 0;

  typedef struct { int who; string tag; } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  dma_bus_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .rx_req(rx_req),
    .tx_done(tx_done), .rx_done(rx_done), .cfg_fixed(cfg_fixed),
    .cfg_tx_first(cfg_tx_first), .cfg_ratio(cfg_ratio),
    .tx_gnt(tx_gnt), .rx_gnt(rx_gnt)
  );

  function automatic int who_now();
    if (tx_gnt && !rx_gnt) return WHO_TX;
    if (rx_gnt && !tx_gnt) return WHO_RX;
    if (!tx_gnt && !rx_gnt) return WHO_NONE;
    return 3;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model of the decision, written from the requirements.
  task automatic push_expect(input bit t, input bit r, input string tag);
    exp_t e;
    e.tag = tag;
    if (t && !r)      e.who = WHO_TX;
    else if (r && !t) e.who = WHO_RX;
    else if (cfg_fixed) e.who = cfg_tx_first ? WHO_TX : WHO_RX;
    else begin
      if (cnt_m >= int'(cfg_ratio) + 1) begin
        e.who = WHO_TX;
        cnt_m = 0;
      end else begin
        e.who = WHO_RX;
        cnt_m++;
      end
    end
    sb_q.push_back(e);
  endtask

  // Monitor: pops an expectation on every new grant.
  int prev_who = WHO_NONE;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int w;
      w = who_now();
      if (w == 3) check("R1 one-hot grants", w, 0);
      if (w != WHO_NONE && prev_who == WHO_NONE) begin
        if (sb_q.size() == 0) check("R3 unexpected grant", w, WHO_NONE);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.tag, w, e.who);
        end
      end
      prev_who = w;
    end
  end

  // Driver: one full grant cycle. Called at a negedge in an idle cycle.
  task automatic one_grant(input bit t, input bit r, input string tag,
                           input bit stray_done = 0, input int new_ratio = -1);
    int waited;
    int w;
    tx_req = t;
    rx_req = r;
    push_expect(t, r, tag);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (who_now() == WHO_NONE && waited < 8);
    check("R5 grant one edge after idle cycle", waited, 1);
    w = who_now();
    if (new_ratio >= 0) cfg_ratio = 2'(new_ratio);
    if (stray_done) begin
      if (w == WHO_TX) rx_done = 1'b1; else tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0; rx_done = 1'b0;
      @(negedge clk);
      check("R4 foreign done ignored", who_now(), w);
    end
    @(negedge clk);
    check("R4 grant held", who_now(), w);
    if (w == WHO_TX) tx_done = 1'b1; else rx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0; rx_done = 1'b0;
    check("R5 grant cleared after done", who_now(), WHO_NONE);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset tx grant low", tx_gnt, 0);
    check("R1 reset rx grant low", rx_gnt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R3 no request no grant", who_now(), WHO_NONE);
    end

    // R1 first weighted contest after reset goes to receive.
    one_grant(1, 1, "R1 first contest after reset");
    one_grant(1, 1, "R8 ratio 1:1 second contest");
    one_grant(1, 1, "R8 ratio 1:1");
    one_grant(1, 1, "R8 ratio 1:1");

    one_grant(1, 0, "R2 lone tx");
    one_grant(0, 1, "R2 lone rx");
    one_grant(1, 0, "R2 lone tx again");

    cfg_ratio = 2'd3;
    for (int i = 0; i < 10; i++) one_grant(1, 1, "R8 ratio 4:1");
    cfg_ratio = 2'd1;
    for (int i = 0; i < 6; i++) one_grant(1, 1, "R8 ratio 2:1");

    cfg_ratio = 2'd2;
    one_grant(1, 1, "R8 ratio 3:1");
    one_grant(1, 1, "R8 ratio 3:1");
    one_grant(1, 0, "R9 lone tx keeps count");
    one_grant(0, 1, "R9 lone rx keeps count");
    cfg_fixed = 1'b1;
    one_grant(1, 1, "R9 fixed contest keeps count");
    cfg_fixed = 1'b0;
    one_grant(1, 1, "R9 count resumes");
    one_grant(1, 1, "R9 forced tx after resume");

    cfg_fixed = 1'b1; cfg_tx_first = 1'b0;
    one_grant(1, 1, "R6 fixed rx wins");
    one_grant(1, 1, "R6 fixed rx wins", 1);
    one_grant(1, 1, "R6 fixed rx wins");
    cfg_tx_first = 1'b1;
    one_grant(1, 1, "R7 fixed tx wins");
    one_grant(1, 1, "R7 fixed tx wins", 1);
    one_grant(0, 1, "R2 lone rx in fixed tx-first");

    cfg_fixed = 1'b0; cfg_tx_first = 1'b0; cfg_ratio = 2'd3;
    while (cnt_m < 3) one_grant(1, 1, "R10 build count");
    one_grant(1, 1, "R10 last favoured before change", 0, 0);
    one_grant(1, 1, "R10 lowered ratio forces tx");
    one_grant(1, 1, "R10 new ratio 1:1");
    one_grant(1, 1, "R10 new ratio 1:1");

    tx_req = 1'b0; rx_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R3 idle at end", who_now(), WHO_NONE);
    end
    check("scoreboard drained", sb_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule